// File: doc/BRIEF.md
# Miss Buffer with Per-Line Age Chains

This block holds memory instructions that could not finish as plain cache hits. It keeps them until their line comes back from DRAM and they can be replayed. Each slot has two parts. The line address sits in a searchable tag store with one write, one read and one compare port. The payload sits in a separate data store with one write and one read port. Free slots form a free list, and an insertion takes the lowest-numbered free slot. When the buffer has no free slot it raises a full flag and refuses new insertions.

Before an insertion is committed, its line address is compared against every live slot. If a live slot with the same line address has no successor, the new slot is linked behind it as that slot's successor. Otherwise the new slot starts a chain of its own as its head. Only a chain head that has not yet sent its DRAM request is offered for issue. When its data returns, the slot becomes ready to replay. Ready slots are replayed lowest index first, whatever order their data returned in. When a replay completes, the slot is freed and can be reused in the next cycle. If the slot had a successor, that successor becomes the head of the chain. Slots for different lines have no mutual ordering.

A consumer takes an issue by pulsing `iss_take` while `iss_valid` is high. It reports returned data with `ret_valid`/`ret_idx`, and it completes the offered replay with `rp_done`.

Top module: `miss_chain_buf`

## Requirements
- R1: After reset no slot is live: `full`, `iss_valid` and `rp_valid` are 0, and `ins_idx` is 0.
- R2: An insertion (`ins_valid` high while `full` is low) takes the lowest-numbered free slot, and `ins_idx` shows that slot before the clock edge.
- R3: `full` is high exactly when all 16 slots are live. An insertion attempted while `full` is high changes nothing, so it never appears later as an issue candidate.
- R4: A slot whose line address matches a live slot that has no successor is linked behind that slot. It is not offered for issue until every older slot in its chain has completed.
- R5: Among chain heads whose request is not yet sent, the lowest index is offered on `iss_idx`, and `iss_addr` carries its stored line address. `iss_take` marks the request sent, so that slot is not offered again.
- R6: `ret_valid` with `ret_idx` naming a live slot whose request has been sent makes that slot ready. Returns may arrive in any order. Among ready slots the lowest index is offered on `rp_idx`.
- R7: While `rp_valid` is high, `rp_data` equals the payload written when the offered slot was inserted.
- R8: `rp_done` while `rp_valid` is high frees the offered slot. From the next cycle that slot can be taken by a new insertion, even while older slots still wait for data.
- R9: Within one chain, slots issue and replay in insertion order, even when that order differs from slot index order.
- R10: If the tail of a chain completes in the same cycle as an insertion with the same line address, the new slot becomes a head of its own and is offered for issue in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ins_valid | input | 1 | Insertion request |
| ins_addr | input | ADDR_W | Line address of the new instruction |
| ins_data | input | DATA_W | Payload of the new instruction |
| full | output | 1 | No free slot remains |
| ins_idx | output | IDX_W | Slot the next insertion will use |
| iss_valid | output | 1 | A chain head is waiting to send its DRAM request |
| iss_idx | output | IDX_W | Slot offered for issue |
| iss_addr | output | ADDR_W | Line address of the offered slot |
| iss_take | input | 1 | Consumer accepts the offered issue |
| ret_valid | input | 1 | DRAM data has returned for a slot |
| ret_idx | input | IDX_W | Slot whose data returned |
| rp_valid | output | 1 | A ready slot is offered for replay |
| rp_idx | output | IDX_W | Slot offered for replay |
| rp_data | output | DATA_W | Payload of the offered slot |
| rp_done | input | 1 | Replay of the offered slot completed; free it |

## Verification
Filling all slots with distinct lines and then draining them checks free-list order and the full refusal. Any stray or leaked slot would show up as an extra or missing issue. Returns in reverse order, with two slots ready at once, separate "ready in return order" from "lowest ready index wins". A three-slot chain whose third member lands in a lower slot than the second tells insertion-order linking apart from index order. Early reuse of a freed slot, and an insertion that collides with a completing tail, check the bookkeeping at the moments slots are freed.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int unsigned SLOTS   = 16;
  localparam int unsigned SLOT_IW = $clog2(SLOTS);
endpackage

// File: rtl/mcb_low_pick.sv
module mcb_low_pick #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mcb_tag_cam.sv
module mcb_tag_cam #(
  parameter int unsigned N      = 16,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned IW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [IW-1:0]     rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] key,
  output logic [N-1:0]      hit
);
  logic [ADDR_W-1:0] tag_q [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IW'(g)) tag_q[g] <= wr_addr;
    end
    assign hit[g] = (tag_q[g] == key);
  end

  assign rd_addr = tag_q[rd_idx];
endmodule

// File: rtl/mcb_data_ram.sv
module mcb_data_ram #(
  parameter int unsigned N      = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem_q [N];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/miss_chain_buf.sv
module miss_chain_buf #(
  parameter int unsigned N      = mcb_pkg::SLOTS,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [DATA_W-1:0] ins_data,
  output logic              full,
  output logic [IDX_W-1:0]  ins_idx,
  output logic              iss_valid,
  output logic [IDX_W-1:0]  iss_idx,
  output logic [ADDR_W-1:0] iss_addr,
  input  logic              iss_take,
  input  logic              ret_valid,
  input  logic [IDX_W-1:0]  ret_idx,
  output logic              rp_valid,
  output logic [IDX_W-1:0]  rp_idx,
  output logic [DATA_W-1:0] rp_data,
  input  logic              rp_done
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  // per-slot state
  logic [N-1:0]     vld_q, vld_d;
  logic [N-1:0]     head_q, head_d;
  logic [N-1:0]     sent_q, sent_d;
  logic [N-1:0]     rdy_q, rdy_d;
  logic [N-1:0]     succ_q, succ_d;
  logic [IDX_W-1:0] nxt_q [N];
  logic [IDX_W-1:0] nxt_d [N];

  logic [N-1:0]     raw_hit, tail_hit;
  logic             free_found, tail_found;
  logic [IDX_W-1:0] tail_idx;
  logic             do_ins, do_free;

  mcb_low_pick #(.N(N)) u_free_pick (
    .req(~vld_q), .found(free_found), .idx(ins_idx));
  mcb_low_pick #(.N(N)) u_tail_pick (
    .req(tail_hit), .found(tail_found), .idx(tail_idx));
  mcb_low_pick #(.N(N)) u_iss_pick (
    .req(vld_q & head_q & ~sent_q), .found(iss_valid), .idx(iss_idx));
  mcb_low_pick #(.N(N)) u_rp_pick (
    .req(vld_q & rdy_q), .found(rp_valid), .idx(rp_idx));

  assign full    = ~free_found;
  assign do_ins  = ins_valid & free_found;
  assign do_free = rp_valid & rp_done;

  mcb_tag_cam #(.N(N), .ADDR_W(ADDR_W)) u_cam (
    .clk(clk), .wr_en(do_ins), .wr_idx(ins_idx), .wr_addr(ins_addr),
    .rd_idx(iss_idx), .rd_addr(iss_addr), .key(ins_addr), .hit(raw_hit));

  mcb_data_ram #(.N(N), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .wr_en(do_ins), .wr_idx(ins_idx), .wr_data(ins_data),
    .rd_idx(rp_idx), .rd_data(rp_data));

  // a live tail of the same line, excluding a slot that is being freed now
  for (genvar g = 0; g < N; g++) begin : g_tail
    assign tail_hit[g] = raw_hit[g] & vld_q[g] & ~succ_q[g]
                       & ~(do_free && rp_idx == IDX_W'(g));
  end

  always_comb begin
    vld_d  = vld_q;
    head_d = head_q;
    sent_d = sent_q;
    rdy_d  = rdy_q;
    succ_d = succ_q;
    for (int i = 0; i < N; i++) nxt_d[i] = nxt_q[i];

    if (iss_valid && iss_take) sent_d[iss_idx] = 1'b1;
    if (ret_valid && vld_q[ret_idx] && sent_q[ret_idx])
      rdy_d[ret_idx] = 1'b1;

    if (do_free) begin
      vld_d[rp_idx]  = 1'b0;
      head_d[rp_idx] = 1'b0;
      sent_d[rp_idx] = 1'b0;
      rdy_d[rp_idx]  = 1'b0;
      succ_d[rp_idx] = 1'b0;
      if (succ_q[rp_idx]) head_d[nxt_q[rp_idx]] = 1'b1;
    end

    if (do_ins) begin
      vld_d[ins_idx]  = 1'b1;
      head_d[ins_idx] = ~tail_found;
      sent_d[ins_idx] = 1'b0;
      rdy_d[ins_idx]  = 1'b0;
      succ_d[ins_idx] = 1'b0;
      if (tail_found) begin
        succ_d[tail_idx] = 1'b1;
        nxt_d[tail_idx]  = ins_idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q  <= '0;
      head_q <= '0;
      sent_q <= '0;
      rdy_q  <= '0;
      succ_q <= '0;
      for (int i = 0; i < N; i++) nxt_q[i] <= '0;
    end else begin
      vld_q  <= vld_d;
      head_q <= head_d;
      sent_q <= sent_d;
      rdy_q  <= rdy_d;
      succ_q <= succ_d;
      for (int i = 0; i < N; i++) nxt_q[i] <= nxt_d[i];
    end
  end
endmodule

// File: rtl/mcb_checker.sv
module mcb_checker #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          ins_valid,
  input logic          full,
  input logic [IW-1:0] ins_idx,
  input logic          iss_valid,
  input logic [IW-1:0] iss_idx,
  input logic          rp_valid,
  input logic          rp_done,
  input logic [IW-1:0] rp_idx,
  input logic [N-1:0]  vld_q,
  input logic [N-1:0]  sent_q,
  input logic [N-1:0]  rdy_q,
  input logic [N-1:0]  tail_hit
);
  a_r2_insert_lands: assert property (@(posedge clk) disable iff (!rst_q_n)
    ins_valid && !full |=> vld_q[$past(ins_idx)]);

  a_r3_full_frozen: assert property (@(posedge clk) disable iff (!rst_q_n)
    full && !(rp_valid && rp_done) |=> $stable(vld_q));

  a_r4_one_tail: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(tail_hit));

  a_r5_offer_unsent: assert property (@(posedge clk) disable iff (!rst_q_n)
    iss_valid |-> vld_q[iss_idx] && !sent_q[iss_idx] && !rdy_q[iss_idx]);

  a_r6_ready_after_send: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rdy_q & ~sent_q) == '0);

  a_r8_slot_freed: assert property (@(posedge clk) disable iff (!rst_q_n)
    rp_valid && rp_done |=> !vld_q[$past(rp_idx)]);
endmodule

bind miss_chain_buf mcb_checker #(.N(N)) u_mcb_checker (
  .clk(clk), .rst_q_n(rst_q_n), .ins_valid(ins_valid), .full(full),
  .ins_idx(ins_idx), .iss_valid(iss_valid), .iss_idx(iss_idx),
  .rp_valid(rp_valid), .rp_done(rp_done), .rp_idx(rp_idx),
  .vld_q(vld_q), .sent_q(sent_q), .rdy_q(rdy_q), .tail_hit(tail_hit));

// File: tb/test_miss_chain_buf.sv
module test_miss_chain_buf;
  localparam int N = 16;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ins_valid, iss_take, ret_valid, rp_done;
  logic [AW-1:0] ins_addr;
  logic [DW-1:0] ins_data;
  logic [IW-1:0] ret_idx;
  logic full, iss_valid, rp_valid;
  logic [IW-1:0] ins_idx, iss_idx, rp_idx;
  logic [AW-1:0] iss_addr;
  logic [DW-1:0] rp_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  miss_chain_buf #(.N(N), .ADDR_W(AW), .DATA_W(DW)) i_miss_chain_buf (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_addr(ins_addr),
    .ins_data(ins_data), .full(full), .ins_idx(ins_idx),
    .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_addr(iss_addr),
    .iss_take(iss_take), .ret_valid(ret_valid), .ret_idx(ret_idx),
    .rp_valid(rp_valid), .rp_idx(rp_idx), .rp_data(rp_data),
    .rp_done(rp_done));

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pay(input logic [AW-1:0] a, input int k);
    return {a, 16'(k + 16'h5A00)};
  endfunction

  task automatic idle();
    ins_valid = 0; iss_take = 0; ret_valid = 0; rp_done = 0;
    ins_addr = '0; ins_data = '0; ret_idx = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  // insert: checks the slot chosen, commits at the next edge
  task automatic ins(input string req, input logic [AW-1:0] a, input int k,
                     input int exp_idx);
    ins_valid = 1; ins_addr = a; ins_data = pay(a, k);
    #1 chk(req, ins_idx, exp_idx);
    @(negedge clk);
    idle();
  endtask

  task automatic take(input string req, input int exp_idx,
                      input logic [AW-1:0] exp_addr);
    #1 chk(req, iss_valid, 1);
    chk(req, iss_idx, exp_idx);
    chk(req, iss_addr, exp_addr);
    iss_take = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic ret(input int idx);
    ret_valid = 1; ret_idx = IW'(idx);
    @(negedge clk);
    idle();
  endtask

  task automatic replay(input string req, input int exp_idx,
                        input logic [DW-1:0] exp_data);
    #1 chk(req, rp_valid, 1);
    chk(req, rp_idx, exp_idx);
    chk({req, "/R7"}, rp_data, exp_data);
    rp_done = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 full", full, 0);
    chk("R1 iss_valid", iss_valid, 0);
    chk("R1 rp_valid", rp_valid, 0);
    chk("R1 ins_idx", ins_idx, 0);
  endtask

  task automatic t_fill();
    do_reset();
    for (int i = 0; i < N; i++) ins("R2 fill slot", AW'(16'h100 + i), i, i);
    #1 chk("R3 full raised", full, 1);
    ins_valid = 1; ins_addr = 16'hFFFF; ins_data = '1;
    @(negedge clk);
    idle();
    #1 chk("R3 still full", full, 1);
    for (int i = 0; i < N; i++) take("R5 issue order", i, AW'(16'h100 + i));
    #1 chk("R3 refused never issued", iss_valid, 0);
  endtask

  task automatic t_out_of_order();
    do_reset();
    ins("R2", 16'h0A0, 0, 0);
    ins("R2", 16'h0B0, 1, 1);
    ins("R2", 16'h0C0, 2, 2);
    take("R5", 0, 16'h0A0);
    take("R5", 1, 16'h0B0);
    take("R5", 2, 16'h0C0);
    #1 chk("R6 none ready yet", rp_valid, 0);
    ret(2);
    replay("R6 first return", 2, pay(16'h0C0, 2));
    ret(1);
    ret(0);
    replay("R6 lowest ready", 0, pay(16'h0A0, 0));
    replay("R6 next ready", 1, pay(16'h0B0, 1));
    #1 chk("R6 drained", rp_valid, 0);
  endtask

  task automatic t_reuse();
    do_reset();
    ins("R2", 16'h200, 0, 0);
    ins("R2", 16'h300, 1, 1);
    take("R5", 0, 16'h200);
    take("R5", 1, 16'h300);
    ret(1);
    replay("R8 younger replays first", 1, pay(16'h300, 1));
    ins("R8 freed slot reused", 16'h400, 7, 1);
    take("R8 new slot issues", 1, 16'h400);
    ret(0);
    replay("R8 older still served", 0, pay(16'h200, 0));
  endtask

  task automatic t_chain();
    do_reset();
    ins("R4", 16'h777, 0, 0);
    ins("R4", 16'h888, 1, 1);
    ins("R4", 16'h777, 2, 2);
    take("R4", 0, 16'h777);
    take("R4", 1, 16'h888);
    #1 chk("R4 linked slot held back", iss_valid, 0);
    ret(1);
    replay("R4", 1, pay(16'h888, 1));
    ins("R9 third member in lower slot", 16'h777, 3, 1);
    #1 chk("R9 third held back", iss_valid, 0);
    ret(0);
    replay("R9 chain first", 0, pay(16'h777, 0));
    take("R9 second member issues", 2, 16'h777);
    #1 chk("R9 third still held", iss_valid, 0);
    ret(2);
    replay("R9 chain second", 2, pay(16'h777, 2));
    take("R9 third member issues", 1, 16'h777);
    ret(1);
    replay("R9 chain third", 1, pay(16'h777, 3));
  endtask

  task automatic t_tail_collide();
    do_reset();
    ins("R10", 16'h999, 0, 0);
    take("R10", 0, 16'h999);
    ret(0);
    #1 chk("R10 ready", rp_valid, 1);
    rp_done = 1;
    ins_valid = 1; ins_addr = 16'h999; ins_data = pay(16'h999, 9);
    #1 chk("R10 slot while tail frees", ins_idx, 1);
    @(negedge clk);
    idle();
    take("R10 new slot heads own chain", 1, 16'h999);
    ret(1);
    replay("R10", 1, pay(16'h999, 9));
  endtask

  initial begin
    rst_n = 0;
    idle();
    t_reset();
    t_fill();
    t_out_of_order();
    t_reuse();
    t_chain();
    t_tail_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule